// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose pin controller for up to 192 pins. The pins are grouped into banks of 32. Each bank has its own register set:

- a level readback of the pin state;
- a direction register that drives the pin output enables;
- an output latch that software changes only through write-one-to-set and write-one-to-clear strobes;
- rising-edge and falling-edge detect enables;
- a sticky edge-status register, cleared by writing one;
- an interrupt gating mask.

Pin inputs are synchronized through two flops before any use. Edges are found by comparing the synchronized level with its value one clock earlier. Any unmasked pending status in any bank drives a single registered interrupt line.

Software reads registers combinationally from the address bus and writes them with a one-cycle write strobe. Register addresses are the kind offset plus the bank offset:

| Register | Kind offset |
|---|---|
| level | 0x00 |
| direction | 0x0C |
| set | 0x18 |
| clear | 0x24 |
| rising enable | 0x30 |
| falling enable | 0x3C |
| edge status | 0x48 |
| interrupt mask | 0x9C |

| Bank | Bank offset |
|---|---|
| 0, 1, 2 | 4 × bank |
| 3 and above | 0x100 + 4 × (bank − 3) |

Top module: `bank_gpio_ctrl`

## Requirements
- R1: After reset, every readable register, `pin_out`, `pin_oe` and `irq` are zero.
- R2: A register is addressed as kind offset plus bank offset, using the two tables above. Any other address reads zero and ignores writes.
- R3: Direction bit 1 makes the pin an output: `pin_oe` follows the direction register, and the direction register reads back what was written.
- R4: Writing to the set address drives high every output latch whose data bit is 1. Writing to the clear address drives those latches low. Zero bits leave latches unchanged. No other write changes `pin_out`. Set and clear addresses read zero.
- R5: The level register reads the pin input as seen two clocks later, whatever the direction.
- R6: An edge is a change of the synchronized level between two consecutive clocks. A rising edge sets the status bit only when the rising enable is 1. A falling edge sets it only when the falling enable is 1. The bit is set one clock after the synchronized level changes.
- R7: A status bit stays 1 until software writes 1 to that bit of the status address. Writing all ones clears every pending bit of the bank.
- R8: If an edge event and a clear of the same status bit fall in the same cycle, the bit stays 1.
- R9: `irq` is 1 exactly one clock after some bank holds a status bit whose mask bit is 1. The masks reset to zero.
- R10: In a partly populated final bank, bits beyond the last pin read zero in every register, and writing them has no effect.
- R11: The level register is read-only: writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| irq | output | 1 | Combined registered interrupt |

## Verification
Edge capture and the software write-one-to-clear of the status register can act on the same bit in the same clock. The bench provokes this collision by enabling both edge polarities on a pin and toggling that pin every cycle, while it writes ones to that bit of the status address on every cycle. Because the synchronized level then changes each clock, an event coincides with every clear. The bit must read back as 1 on each cycle and after the burst ends. The per-cycle reference model and a property on the status bits both judge this outcome. A long random phase then mixes status clears with random pin activity, so that collisions also happen on pins and cycles that were not chosen by hand.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_KINDS = 8;

  typedef enum logic [2:0] {
    RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_RISE, RK_FALL, RK_STAT, RK_MASK
  } reg_kind_e;

  function automatic int unsigned kind_offset(input int k);
    case (k)
      0:       return 'h00;
      1:       return 'h0C;
      2:       return 'h18;
      3:       return 'h24;
      4:       return 'h30;
      5:       return 'h3C;
      6:       return 'h48;
      default: return 'h9C;
    endcase
  endfunction

  function automatic int unsigned bank_offset(input int b);
    return (b < 3) ? b * 4 : 'h100 + (b - 3) * 4;
  endfunction

  function automatic int unsigned reg_addr(input int b, input int k);
    return kind_offset(k) + bank_offset(b);
  endfunction

  function automatic logic [BANK_W-1:0] pop_mask(input int b, input int npins);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = ((b * BANK_W + i) < npins);
    return m;
  endfunction

  function automatic logic [BANK_W-1:0] edge_hits(
    input logic [BANK_W-1:0] now_lvl, input logic [BANK_W-1:0] old_lvl,
    input logic [BANK_W-1:0] rise_en, input logic [BANK_W-1:0] fall_en);
    return (now_lvl & ~old_lvl & rise_en) | (~now_lvl & old_lvl & fall_en);
  endfunction
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/bgc_decode.sv
module bgc_decode
  import bgc_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]                         addr,
  output logic [NUM_BANKS-1:0][NUM_KINDS-1:0]       hit
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      localparam int unsigned ADDR_HIT = reg_addr(b, k);
      assign hit[b][k] = (addr == ADDR_W'(ADDR_HIT));
    end
  end
endmodule

// File: rtl/bgc_bank.sv
module bgc_bank
  import bgc_pkg::*;
#(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BANK_W-1:0]    lvl,
  input  logic [NUM_KINDS-1:0] hit,
  input  logic                 we,
  input  logic [BANK_W-1:0]    wdata,
  output logic [BANK_W-1:0]    rd_val,
  output logic [BANK_W-1:0]    out_lat,
  output logic [BANK_W-1:0]    dir_lat,
  output logic [BANK_W-1:0]    evt,
  output logic [BANK_W-1:0]    stat,
  output logic [BANK_W-1:0]    clr_bits,
  output logic                 pend
);
  logic [BANK_W-1:0] rise_q, fall_q, mask_q, prev_q;
  logic [BANK_W-1:0] set_bits, drop_bits, wmask;

  assign wmask     = wdata & VALID;
  assign set_bits  = (we && hit[RK_SET]) ? wmask : '0;
  assign drop_bits = (we && hit[RK_CLR]) ? wmask : '0;
  assign clr_bits  = (we && hit[RK_STAT]) ? wmask : '0;
  assign evt       = edge_hits(lvl, prev_q, rise_q, fall_q) & VALID;
  assign pend      = |(stat & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_lat <= '0;
      out_lat <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      mask_q  <= '0;
      stat    <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= lvl;
      out_lat <= (out_lat | set_bits) & ~drop_bits;
      stat    <= (stat & ~clr_bits) | evt;
      if (we && hit[RK_DIR])  dir_lat <= wmask;
      if (we && hit[RK_RISE]) rise_q  <= wmask;
      if (we && hit[RK_FALL]) fall_q  <= wmask;
      if (we && hit[RK_MASK]) mask_q  <= wmask;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit[RK_LEVEL]) rd_val |= lvl & VALID;
    if (hit[RK_DIR])   rd_val |= dir_lat;
    if (hit[RK_RISE])  rd_val |= rise_q;
    if (hit[RK_FALL])  rd_val |= fall_q;
    if (hit[RK_STAT])  rd_val |= stat;
    if (hit[RK_MASK])  rd_val |= mask_q;
  end
endmodule

// File: rtl/bank_gpio_ctrl.sv
module bank_gpio_ctrl
  import bgc_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;

  logic [NUM_PINS-1:0]                  pin_sync;
  logic [PAD_W-1:0]                     lvl_pad, out_pad, oe_pad;
  logic [PAD_W-1:0]                     evt_all, stat_all, clr_all;
  logic [NUM_BANKS-1:0][NUM_KINDS-1:0]  hit;
  logic [BANK_W-1:0]                    rd_val [NUM_BANKS];
  logic [NUM_BANKS-1:0]                 pend;
  logic                                 pend_any, out_wr_any, dir_wr_any;

  bgc_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign lvl_pad = PAD_W'(pin_sync);

  bgc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bgc_bank #(.VALID(pop_mask(b, NUM_PINS))) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_pad[b*BANK_W +: BANK_W]),
      .hit      (hit[b]),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .rd_val   (rd_val[b]),
      .out_lat  (out_pad[b*BANK_W +: BANK_W]),
      .dir_lat  (oe_pad[b*BANK_W +: BANK_W]),
      .evt      (evt_all[b*BANK_W +: BANK_W]),
      .stat     (stat_all[b*BANK_W +: BANK_W]),
      .clr_bits (clr_all[b*BANK_W +: BANK_W]),
      .pend     (pend[b])
    );
  end

  if (PAD_W > NUM_PINS) begin : g_spare
    logic spare_unused;
    assign spare_unused = ^{out_pad[PAD_W-1:NUM_PINS], oe_pad[PAD_W-1:NUM_PINS]};
  end

  assign pin_out  = out_pad[NUM_PINS-1:0];
  assign pin_oe   = oe_pad[NUM_PINS-1:0];
  assign pend_any = |pend;

  always_comb begin
    bus_rdata  = '0;
    out_wr_any = 1'b0;
    dir_wr_any = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bus_rdata  |= rd_val[b];
      out_wr_any |= bus_we & (hit[b][RK_SET] | hit[b][RK_CLR]);
      dir_wr_any |= bus_we & hit[b][RK_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend_any;
  end
endmodule

// File: rtl/bgc_chk.sv
module bgc_chk #(
  parameter int PAD_W    = 64,
  parameter int NUM_PINS = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PAD_W-1:0]    evt_all,
  input logic [PAD_W-1:0]    stat_all,
  input logic [PAD_W-1:0]    clr_all,
  input logic                pend_any,
  input logic                out_wr_any,
  input logic                dir_wr_any,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq
);
  // R7
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_all) & ~$past(clr_all)) & ~stat_all) == '0));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_all) & ~stat_all) == '0));

  // R6
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_all & ~$past(stat_all) & ~$past(evt_all)) == '0));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> irq);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |=> !irq);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr_any |=> $stable(pin_out));

  // R3
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr_any |=> $stable(pin_oe));
endmodule

bind bank_gpio_ctrl bgc_chk #(.PAD_W(PAD_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_all(evt_all), .stat_all(stat_all),
  .clr_all(clr_all), .pend_any(pend_any), .out_wr_any(out_wr_any),
  .dir_wr_any(dir_wr_any), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/bank_gpio_ctrl_tb.sv
module bank_gpio_ctrl_tb;
  localparam int NP     = 40;
  localparam int AW     = 10;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int    n_vec = 0, n_bad = 0;
  bit    armed = 0;
  string phase = "R1";

  // reference model state, one entry per pin
  bit [NP-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_mask, m_s1, m_s2, m_prev;
  bit [NP-1:0] m_evt, m_clr;
  bit          m_irq;

  always #(PERIOD/2) clk = ~clk;

  bank_gpio_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // kind 0..7 = level, dir, set, clr, rise, fall, status, mask
  function automatic int addr_of(input int kind, input int bank);
    int slot;
    slot = (kind == 7) ? 13 : kind;
    return ((bank >= 3) ? 256 : 0) + (bank % 3) * 4 + slot * 12;
  endfunction

  function automatic void split(input int a, output int kind, output int bank);
    int low, idx, kk;
    kind = -1; bank = -1;
    if (a % 4 != 0 || a >= 512) return;
    low = a % 256; idx = low / 4; kk = idx / 3;
    bank = (a >= 256 ? 3 : 0) + idx % 3;
    if (bank * 32 >= NP) begin bank = -1; return; end
    if (kk <= 6) kind = kk;
    else if (kk == 13) kind = 7;
    else bank = -1;
  endfunction

  function automatic logic [31:0] slice(input bit [NP-1:0] v, input int bank);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (bank * 32 + i < NP) r[i] = v[bank*32+i];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int k, b;
    split(a, k, b);
    if (k < 0) return '0;
    case (k)
      0: return slice(m_s2, b);
      1: return slice(m_dir, b);
      4: return slice(m_rise, b);
      5: return slice(m_fall, b);
      6: return slice(m_stat, b);
      7: return slice(m_mask, b);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int k, b;
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
      m_mask = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 0;
    end else begin
      m_irq = |(m_stat & m_mask);
      m_clr = '0;
      for (int i = 0; i < NP; i++)
        m_evt[i] = (m_s2[i] && !m_prev[i] && m_rise[i]) || (!m_s2[i] && m_prev[i] && m_fall[i]);
      split(int'(bus_addr), k, b);
      if (bus_we && k >= 0) begin
        for (int i = 0; i < 32; i++) begin
          if (b * 32 + i < NP) begin
            case (k)
              1: m_dir[b*32+i]  = bus_wdata[i];
              2: if (bus_wdata[i]) m_out[b*32+i] = 1'b1;
              3: if (bus_wdata[i]) m_out[b*32+i] = 1'b0;
              4: m_rise[b*32+i] = bus_wdata[i];
              5: m_fall[b*32+i] = bus_wdata[i];
              6: m_clr[b*32+i]  = bus_wdata[i];
              7: m_mask[b*32+i] = bus_wdata[i];
              default: ;
            endcase
          end
        end
      end
      m_stat = (m_stat & ~m_clr) | m_evt;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    logic [31:0] er;
    if (armed) begin
      n_vec++;
      er = exp_read(int'(bus_addr));
      if (bus_rdata !== er) begin
        n_bad++;
        $display("FAIL %s rdata @%0h: actual %h expected %h", phase, bus_addr, bus_rdata, er);
      end else if (pin_out !== m_out) begin
        n_bad++;
        $display("FAIL %s pin_out: actual %h expected %h", phase, pin_out, m_out);
      end else if (pin_oe !== m_dir) begin
        n_bad++;
        $display("FAIL %s pin_oe: actual %h expected %h", phase, pin_oe, m_dir);
      end else if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq: actual %b expected %b", phase, irq, m_irq);
      end
    end
  end

  task automatic cyc(input int a, input bit we, input logic [31:0] wd, input logic [NP-1:0] pins);
    @(posedge clk);
    #(PERIOD/4);
    bus_addr = AW'(a); bus_we = we; bus_wdata = wd; pin_in = pins;
  endtask

  task automatic wr(input int kind, input int bank, input logic [31:0] wd);
    cyc(addr_of(kind, bank), 1'b1, wd, pin_in);
  endtask

  task automatic rd(input int kind, input int bank);
    cyc(addr_of(kind, bank), 1'b0, '0, pin_in);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4) rst_n = 1'b1;
    armed = 1;
    // R1: reset contents of every register kind
    phase = "R1";
    for (int k = 0; k < 8; k++) begin rd(k, 0); rd(k, 1); end
    // R3: direction and output enables
    phase = "R3";
    wr(1, 0, 32'hF0F0_00FF); rd(1, 0); wr(1, 1, 32'h0000_00A5); rd(1, 1);
    // R4: set/clear strobes, readback zero
    phase = "R4";
    wr(2, 0, 32'h0000_FFFF); rd(2, 0); wr(3, 0, 32'h0000_0F0F); rd(3, 0);
    wr(2, 1, 32'h0000_0033); wr(3, 1, 32'h0); wr(1, 0, 32'h0); rd(0, 0);
    // R10: unpopulated bits of bank 1
    phase = "R10";
    wr(1, 1, 32'hFFFF_FFFF); rd(1, 1); wr(2, 1, 32'hFFFF_FF00); wr(7, 1, 32'hFFFF_FFFF); rd(7, 1);
    wr(7, 1, 32'h0);
    // R2: bank offsets, unmapped addresses
    phase = "R2";
    cyc(addr_of(1, 2), 1'b1, 32'hFFFF_FFFF, pin_in); rd(1, 2);
    cyc('h0C + 2, 1'b1, 32'hFFFF_FFFF, pin_in); rd(1, 0);
    cyc('h2F0, 1'b1, 32'h1234_5678, pin_in); rd(1, 1);
    // R5: level follows pins through two flops, any direction
    phase = "R5";
    for (int i = 0; i < 12; i++) cyc(addr_of(0, i % 2), 1'b0, '0, NP'({$urandom(), $urandom()}));
    // R11: level register is read-only
    phase = "R11";
    wr(0, 0, 32'hFFFF_FFFF); wr(0, 1, 32'hFFFF_FFFF); rd(0, 0);
    // R6: rising on bits 0..7, falling on 8..15, bank 1 both on bits 0..3
    phase = "R6";
    cyc(addr_of(6, 0), 1'b1, 32'hFFFF_FFFF, '0); wr(6, 1, 32'hFFFF_FFFF);
    wr(4, 0, 32'h0000_00FF); wr(5, 0, 32'h0000_FF00);
    wr(4, 1, 32'h0000_000F); wr(5, 1, 32'h0000_000F);
    cyc(addr_of(6, 0), 1'b0, '0, NP'(64'h0000_0005_0000_AAAA));
    repeat (4) rd(6, 0);
    cyc(addr_of(6, 1), 1'b0, '0, NP'(64'h0000_0000_0000_0000));
    repeat (4) rd(6, 1); rd(6, 0);
    // R7: partial clear, then all-ones clear
    phase = "R7";
    wr(6, 0, 32'h0000_0002); rd(6, 0); rd(6, 0);
    wr(6, 0, 32'hFFFF_FFFF); rd(6, 0); rd(6, 1);
    wr(6, 1, 32'hFFFF_FFFF); rd(6, 1);
    // R9: mask gating of the interrupt
    phase = "R9";
    cyc(addr_of(6, 1), 1'b0, '0, NP'(64'h0000_0001_0000_0000));
    repeat (4) rd(6, 1);
    wr(7, 0, 32'hFFFF_FFFF); rd(7, 0); rd(7, 0);
    wr(7, 1, 32'h0000_0001); rd(6, 1); rd(6, 1);
    wr(6, 1, 32'h0000_0001); rd(6, 1); rd(6, 1);
    // R8: event and clear on the same bit in the same cycle
    phase = "R8";
    wr(4, 0, 32'h0000_0008); wr(5, 0, 32'h0000_0008);
    for (int i = 0; i < 24; i++)
      cyc(addr_of(6, 0), 1'b1, 32'h0000_0008, pin_in ^ NP'(8));
    rd(6, 0); rd(6, 0);
    // R2: random mix of all register kinds and pin activity
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      int a;
      if ($urandom_range(0, 9) == 0) a = $urandom_range(0, (1 << AW) - 1);
      else a = addr_of($urandom_range(0, 7), $urandom_range(0, 1));
      cyc(a, $urandom_range(0, 2) == 0, $urandom(),
          ($urandom_range(0, 3) == 0) ? NP'({$urandom(), $urandom()}) : pin_in);
    end
    rd(6, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule